// File: doc/BRIEF.md
# Shopping Cart Running-Total Datapath

This block keeps the bill for one shopping cart. Each operation arrives as a 3-bit operation code, a 5-bit lookup code and a 16-bit data word, and is qualified by a valid strobe. A writable price table indexed by product code supplies item prices. A constant coupon table supplies discounts. A 21-bit running total, a last-item-price register and a one-cycle done flag are driven out.

Removals and deductions are done by adding the two's complement of the amount to the total. The result is clamped at zero when it would go negative and at full scale when it would overflow. Checkout adds a fixed tax share of the total. Two further operation codes capture the halves of a 32-bit store-card word and present it to a downstream cipher.

The total is kept internally in units of 1/128. On the output port the whole-unit part sits in bits 13:0 and the 1/128 fraction in bits 20:14.

Top module: `cart_tally`

## Requirements
- R1: A synchronous reset clears the total, the last price, the done flag and the card word, and loads price entry i with 10*i+5 whole units.
- R2: When the valid strobe is low, or the operation code is 000, the total, last price, done flag and card word hold their values.
- R3: Operation 001 adds the price at the lookup code to the total and copies that price to the last-price output. A result above full scale (all 21 bits set) clamps to full scale.
- R4: Operation 010 subtracts the price at the lookup code from the total and copies that price to the last-price output. A negative result clamps to zero.
- R5: Operation 011 applies the coupon at code c and leaves the last price unchanged. An even c is a fixed deduction of 3*c+2 whole units. An odd c is a percentage of 5+(c>>1) percent, and the deduction is floor(t*pct/100), where t is in 1/128 units. A negative result clamps to zero.
- R6: Operation 100 writes data bits 9:0 into the price entry at the lookup code. The total and last price are unchanged, and later add and remove operations use the new price.
- R7: Operation 101 adds floor(t*8/128) to the total t (in 1/128 units), clamping at full scale. The done output is high for exactly the one cycle after the sampling edge.
- R8: The total output carries the whole-unit part in bits 13:0 and the 1/128 fraction in bits 20:14.
- R9: Operation 110 loads the data word into card bits 15:0 and operation 111 loads it into bits 31:16. Neither operation changes the total.
- R10: Every operation is sampled on a rising edge with valid high, and its result is visible on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | Qualifies the operation inputs |
| opCode | input | 3 | Operation select |
| lookupCode | input | 5 | Product or coupon code |
| dataIn | input | 16 | New price or card half |
| totalOut | output | 21 | Running total, fraction in 20:14 and whole units in 13:0 |
| lastPriceOut | output | 10 | Price of the last item added or removed |
| doneOut | output | 1 | One-cycle checkout pulse |
| cardWordOut | output | 32 | Captured store-card word |

## Verification
The bench builds the block with its default parameters: 5-bit codes, a 14-bit whole part with a 7-bit fraction, and a tax factor of 8/128. With 32 entries, random codes touch every price and every coupon entry. The largest default price is 315, so about 53 additions reach the full-scale clamp and a few removals reach the zero clamp within a short run. Random price rewrites mixed with adds and removes exercise the writable table against a bench-side copy. Directed cases cover both clamps, checkout at full scale, and the placement of the fraction field.

// File: rtl/cart_pkg.sv
package cart_pkg;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_ADD      = 3'd1,
    OP_REMOVE   = 3'd2,
    OP_COUPON   = 3'd3,
    OP_SETPRICE = 3'd4,
    OP_CHECKOUT = 3'd5,
    OP_CARD_LO  = 3'd6,
    OP_CARD_HI  = 3'd7
  } cartOp_t;

  typedef struct packed {
    logic addItem;
    logic removeItem;
    logic applyCoupon;
    logic writePrice;
    logic checkout;
    logic loadCardLo;
    logic loadCardHi;
  } cartStrobes_t;

  // Price loaded into entry idx at reset, in whole units.
  function automatic int defaultPrice(input int idx);
    return 10 * idx + 5;
  endfunction

  // Odd coupon codes are percentages, even codes fixed amounts.
  function automatic logic couponIsPercent(input int idx);
    return idx[0];
  endfunction

  function automatic int couponValue(input int idx);
    if (idx[0]) return 5 + (idx >> 1);
    return 3 * idx + 2;
  endfunction

endpackage

// File: rtl/cart_ctrl.sv
module cart_ctrl
  import cart_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         opValid,
  input  logic [2:0]   opCode,
  output cartStrobes_t strobes,
  output logic         doneOut
);

  logic doneQ;

  always_comb begin
    strobes = '0;
    if (opValid) begin
      case (cartOp_t'(opCode))
        OP_ADD:      strobes.addItem     = 1'b1;
        OP_REMOVE:   strobes.removeItem  = 1'b1;
        OP_COUPON:   strobes.applyCoupon = 1'b1;
        OP_SETPRICE: strobes.writePrice  = 1'b1;
        OP_CHECKOUT: strobes.checkout    = 1'b1;
        OP_CARD_LO:  strobes.loadCardLo  = 1'b1;
        OP_CARD_HI:  strobes.loadCardHi  = 1'b1;
        default:     strobes = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) doneQ <= 1'b0;
    else     doneQ <= strobes.checkout;
  end

  assign doneOut = doneQ;

  // R10: at most one operation strobe per cycle
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes));

  // R7: done only ever follows a checkout edge
  a_r7_done_after_checkout: assert property (@(posedge clk) disable iff (rst)
    doneOut |-> $past(opValid && opCode == 3'd5));

  // R2: a cycle without valid leaves done low next cycle
  a_r2_idle_no_done: assert property (@(posedge clk) disable iff (rst)
    !opValid |=> !doneOut);

endmodule

// File: rtl/cart_sat_add.sv
// Adds or subtracts (via two's complement) a magnitude and clamps the result
// into [0, 2**OUT_W - 1]. Both operands must stay below 2**(W-1).
module cart_sat_add #(
  parameter int W     = 31,
  parameter int OUT_W = 21
) (
  input  logic [W-1:0]     base,
  input  logic [W-1:0]     mag,
  input  logic             neg,
  output logic [OUT_W-1:0] result
);

  localparam logic [W-1:0] MAX_VAL = W'((64'd1 << OUT_W) - 64'd1);

  logic [W-1:0] addend;
  logic [W-1:0] sum;

  always_comb begin
    addend = neg ? (~mag + W'(1)) : mag;
    sum    = base + addend;
    if (neg && sum[W-1])
      result = '0;
    else if (!neg && sum > MAX_VAL)
      result = MAX_VAL[OUT_W-1:0];
    else
      result = sum[OUT_W-1:0];
  end

endmodule

// File: rtl/cart_datapath.sv
module cart_datapath
  import cart_pkg::*;
#(
  parameter int CODE_W    = 5,
  parameter int PRICE_W   = 10,
  parameter int DATA_W    = 16,
  parameter int INT_W     = 14,
  parameter int FRAC_W    = 7,
  parameter int CVAL_W    = 9,
  parameter int TAX_NUM   = 8,
  parameter int TAX_SHIFT = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  cartStrobes_t        strobes,
  input  logic [CODE_W-1:0]   lookupCode,
  input  logic [DATA_W-1:0]   dataIn,
  output logic [INT_W+FRAC_W-1:0] totalQ,
  output logic [PRICE_W-1:0]  lastPriceQ,
  output logic [2*DATA_W-1:0] cardQ
);

  localparam int TOTAL_W   = INT_W + FRAC_W;
  localparam int DEPTH     = 1 << CODE_W;
  localparam int EXT_W     = TOTAL_W + CVAL_W + 1;
  localparam int PCT_SCALE = 100;

  logic [PRICE_W-1:0] priceMem   [DEPTH];
  logic [CVAL_W:0]    couponRom  [DEPTH];
  logic [PRICE_W-1:0] priceRd;
  logic [CVAL_W:0]    couponRd;
  logic [EXT_W-1:0]   priceExt;
  logic [EXT_W-1:0]   pctAmt;
  logic [EXT_W-1:0]   flatAmt;
  logic [EXT_W-1:0]   taxAmt;
  logic [EXT_W-1:0]   magSel;
  logic               negSel;
  logic               totalWe;
  logic [TOTAL_W-1:0] nextTotal;

  // Constant coupon table: {isPercent, value}
  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      couponRom[i] = {couponIsPercent(i), CVAL_W'(couponValue(i))};
  end

  // Writable price table
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst)
        priceMem[i] <= PRICE_W'(defaultPrice(i));
      else if (strobes.writePrice && lookupCode == CODE_W'(i))
        priceMem[i] <= dataIn[PRICE_W-1:0];
    end
  end

  assign priceRd  = priceMem[lookupCode];
  assign couponRd = couponRom[lookupCode];
  assign priceExt = EXT_W'(priceRd) << FRAC_W;
  assign flatAmt  = EXT_W'(couponRd[CVAL_W-1:0]) << FRAC_W;
  assign pctAmt   = (EXT_W'(totalQ) * EXT_W'(couponRd[CVAL_W-1:0])) / EXT_W'(PCT_SCALE);

  generate
    if (TAX_NUM == 0) begin : g_no_tax
      assign taxAmt = '0;
    end else begin : g_tax
      assign taxAmt = (EXT_W'(totalQ) * EXT_W'(TAX_NUM)) >> TAX_SHIFT;
    end
  endgenerate

  always_comb begin
    magSel  = '0;
    negSel  = 1'b0;
    totalWe = 1'b1;
    if (strobes.addItem) begin
      magSel = priceExt;
    end else if (strobes.removeItem) begin
      magSel = priceExt;
      negSel = 1'b1;
    end else if (strobes.applyCoupon) begin
      magSel = couponRd[CVAL_W] ? pctAmt : flatAmt;
      negSel = 1'b1;
    end else if (strobes.checkout) begin
      magSel = taxAmt;
    end else begin
      totalWe = 1'b0;
    end
  end

  cart_sat_add #(.W(EXT_W), .OUT_W(TOTAL_W)) u_add (
    .base  (EXT_W'(totalQ)),
    .mag   (magSel),
    .neg   (negSel),
    .result(nextTotal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      totalQ     <= '0;
      lastPriceQ <= '0;
      cardQ      <= '0;
    end else begin
      if (totalWe) totalQ <= nextTotal;
      if (strobes.addItem || strobes.removeItem) lastPriceQ <= priceRd;
      if (strobes.loadCardLo) cardQ[DATA_W-1:0]        <= dataIn;
      if (strobes.loadCardHi) cardQ[2*DATA_W-1:DATA_W] <= dataIn;
    end
  end

  a_r3_add_nondecreasing: assert property (@(posedge clk) disable iff (rst)
    strobes.addItem |=> totalQ >= $past(totalQ));

  a_r4_remove_nonincreasing: assert property (@(posedge clk) disable iff (rst)
    strobes.removeItem |=> totalQ <= $past(totalQ));

  a_r5_coupon_nonincreasing: assert property (@(posedge clk) disable iff (rst)
    strobes.applyCoupon |=> totalQ <= $past(totalQ));

  a_r7_checkout_nondecreasing: assert property (@(posedge clk) disable iff (rst)
    strobes.checkout |=> totalQ >= $past(totalQ));

  a_r6_write_keeps_total: assert property (@(posedge clk) disable iff (rst)
    strobes.writePrice |=> $stable(totalQ) && $stable(lastPriceQ));

  a_r9_card_keeps_total: assert property (@(posedge clk) disable iff (rst)
    (strobes.loadCardLo || strobes.loadCardHi) |=> $stable(totalQ));

endmodule

// File: rtl/cart_tally.sv
module cart_tally
  import cart_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        opValid,
  input  logic [2:0]  opCode,
  input  logic [4:0]  lookupCode,
  input  logic [15:0] dataIn,
  output logic [20:0] totalOut,
  output logic [9:0]  lastPriceOut,
  output logic        doneOut,
  output logic [31:0] cardWordOut
);

  localparam int INT_W  = 14;
  localparam int FRAC_W = 7;

  cartStrobes_t             strobes;
  logic [INT_W+FRAC_W-1:0]  totalQ;

  cart_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opValid(opValid),
    .opCode (opCode),
    .strobes(strobes),
    .doneOut(doneOut)
  );

  cart_datapath #(
    .CODE_W(5), .PRICE_W(10), .DATA_W(16),
    .INT_W(INT_W), .FRAC_W(FRAC_W), .CVAL_W(9),
    .TAX_NUM(8), .TAX_SHIFT(7)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .lookupCode(lookupCode),
    .dataIn    (dataIn),
    .totalQ    (totalQ),
    .lastPriceQ(lastPriceOut),
    .cardQ     (cardWordOut)
  );

  // R8: fraction in the upper field, whole units in the lower field
  assign totalOut = {totalQ[FRAC_W-1:0], totalQ[INT_W+FRAC_W-1:FRAC_W]};

endmodule

// File: tb/cart_tally_test.sv
module cart_tally_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        opValid;
  logic [2:0]  opCode;
  logic [4:0]  lookupCode;
  logic [15:0] dataIn;
  logic [20:0] totalOut;
  logic [9:0]  lastPriceOut;
  logic        doneOut;
  logic [31:0] cardWordOut;

  int checks = 0;
  int fails  = 0;

  longint mTotal;
  longint mLast;
  longint mCard;
  longint mPrice [32];

  localparam longint MAXT = (64'd1 << 21) - 1;

  cart_tally uut (
    .clk(clk), .rst(rst), .opValid(opValid), .opCode(opCode),
    .lookupCode(lookupCode), .dataIn(dataIn), .totalOut(totalOut),
    .lastPriceOut(lastPriceOut), .doneOut(doneOut), .cardWordOut(cardWordOut)
  );

  always #5 clk = ~clk;

  function automatic longint clampT(input longint v);
    if (v < 0) return 0;
    if (v > MAXT) return MAXT;
    return v;
  endfunction

  function automatic longint fmtTotal(input longint t);
    return ((t & 127) << 14) | (t >> 7);
  endfunction

  function automatic longint couponCut(input longint t, input int c);
    if (c % 2 == 1) return (t * (5 + (c >> 1))) / 100;
    return longint'(3 * c + 2) * 128;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mTotal = 0; mLast = 0; mCard = 0;
    for (int i = 0; i < 32; i++) mPrice[i] = 10 * i + 5;
  endtask

  task automatic doOp(input logic v, input int op, input int code, input int data);
    string tag;
    @(negedge clk);
    opValid = v; opCode = 3'(op); lookupCode = 5'(code); dataIn = 16'(data);
    tag = "R2";
    if (v) begin
      case (op)
        1: begin tag = "R3"; mTotal = clampT(mTotal + mPrice[code] * 128); mLast = mPrice[code]; end
        2: begin tag = "R4"; mTotal = clampT(mTotal - mPrice[code] * 128); mLast = mPrice[code]; end
        3: begin tag = "R5"; mTotal = clampT(mTotal - couponCut(mTotal, code)); end
        4: begin tag = "R6"; mPrice[code] = data & 1023; end
        5: begin tag = "R7"; mTotal = clampT(mTotal + ((mTotal * 8) >> 7)); end
        6: begin tag = "R9"; mCard = (mCard & 64'hFFFF0000) | (data & 16'hFFFF); end
        7: begin tag = "R9"; mCard = (mCard & 64'h0000FFFF) | (longint'(data & 16'hFFFF) << 16); end
        default: tag = "R2";
      endcase
    end
    @(negedge clk);
    opValid = 1'b0;
    chk({tag, " R10 total"}, longint'(totalOut), fmtTotal(mTotal));
    chk({tag, " last price"}, longint'(lastPriceOut), mLast);
    chk({tag, " R7 done"}, longint'(doneOut), longint'(v && op == 5));
    chk({tag, " card"}, longint'(cardWordOut), mCard);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; opValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    modelReset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; opValid = 1'b0; opCode = '0; lookupCode = '0; dataIn = '0;
    modelReset();
    void'($urandom(32'd525));
    doReset();

    // R1: reset state and default prices
    chk("R1 total", longint'(totalOut), 0);
    chk("R1 last", longint'(lastPriceOut), 0);
    chk("R1 done", longint'(doneOut), 0);
    chk("R1 card", longint'(cardWordOut), 0);
    doOp(1, 1, 7, 0);
    chk("R1 default price 7", longint'(lastPriceOut), 75);

    // R2: valid low with an add code is ignored; opcode 000 ignored
    doOp(0, 1, 31, 0);
    doOp(1, 0, 31, 0);

    // R8: 75 + checkout -> 9600 + 600 = 10200 = 79 + 88/128
    doOp(1, 5, 0, 0);
    chk("R8 whole field", longint'(totalOut[13:0]), 79);
    chk("R8 fraction field", longint'(totalOut[20:14]), 88);
    doOp(1, 0, 0, 0); // R7 done drops after one cycle

    // R4: remove to zero and past it
    doOp(1, 2, 31, 0);
    doOp(1, 2, 31, 0);
    chk("R4 clamp zero", longint'(totalOut), 0);
    doOp(1, 3, 3, 0);
    doOp(1, 3, 4, 0);

    // R6: rewrite a price and use it
    doOp(1, 4, 2, 16'hFC00 | 999);
    doOp(1, 1, 2, 0);
    chk("R6 new price used", longint'(lastPriceOut), 999);

    // R3: saturate at full scale, then checkout stays there
    for (int i = 0; i < 60; i++) doOp(1, 1, 31, 0);
    chk("R3 clamp max", longint'(totalOut), fmtTotal(MAXT));
    doOp(1, 5, 0, 0);
    chk("R7 clamp max", longint'(totalOut), fmtTotal(MAXT));

    // R9: card halves
    doOp(1, 6, 0, 16'hBEEF);
    doOp(1, 7, 0, 16'h1234);
    chk("R9 card word", longint'(cardWordOut), 64'h1234BEEF);

    // Random mix
    doReset();
    for (int n = 0; n < 3000; n++) begin
      int r;
      int op;
      r = int'($urandom_range(0, 99));
      if (r < 35) op = 1;
      else if (r < 55) op = 2;
      else if (r < 70) op = 3;
      else if (r < 78) op = 4;
      else if (r < 86) op = 5;
      else if (r < 92) op = int'($urandom_range(6, 7));
      else op = 0;
      doOp(1'($urandom_range(0, 9) != 0), op, int'($urandom_range(0, 31)),
           int'($urandom_range(0, 65535)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule